// File: doc/BRIEF.md
# Equalizer Sweep Training Sequencer

This block is the control sequencer that picks the receive feed-forward equalizer setting for one serial lane. On a start pulse it checks that the lane is of the right type. It then programs the line-detect settings, waits for them to settle, and confirms that a signal is present and that the clock-data recovery has locked. If any of these checks fails, it stops with a failure.

When the gate is passed, it forces the equalizer and runs one training trial for each equalizer code, in ascending order. Each trial arms the pattern checker and waits for it. It then applies the code and raises training start, and polls the PHY's completion flag once per tick until a timeout count runs out. The trial's figure of merit comes from a bit field of the saved-equalizer status word.

The code with the strictly largest figure wins. The sequencer then retrains once on that code, and it reports pass only when that retraining succeeds. All waits are parameters counted in clock cycles.

Top module: `eqsweep_seq`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, trn_start_o, pat_en_o and pat_rst_o are 0, best_code_o is 0, and dfe_force_o is 1.
- R2: busy_o is high from the cycle after an accepted start_i until done_o rises. done_o is a one-cycle pulse, taken in the cycle that busy_o falls. A start_i seen while busy_o is high has no effect.
- R3: A start with lane_sfi_i low raises done_o with pass_o low on the second clock edge after start_i is sampled, and no training start is ever raised.
- R4: On an accepted start with lane_sfi_i high, the sequencer sets sq_thresh_o to 0xC, sets dgl_pos_o and dgl_neg_o to 0xF, and sets dgl_en_o and cdr_det_en_o to 1. It then waits SETTLE_CYC cycles before it samples the line status.
- R5: If, at the line check, sq_det_i is 1 (no signal) or cdr_lock_i is 0, the run ends with pass_o low, exactly SETTLE_CYC+2 edges after start_i is sampled, and no training is started.
- R6: Before the first trial, dfe_force_o is set to 0, eq_cap_o to 0xF and eq_force_o to 1.
- R7: The sweep runs codes 0 to NUM_CODES-1 in ascending order. Every trial sets pat_sel_o to 0xE, pat_data_o to 0x64 and pat_en_o to 1. It waits PAT_WAIT_CYC cycles, and only then drives eq_code_o with the trial code and raises trn_start_o. eq_code_o is held while trn_start_o is high.
- R8: trn_done_i is sampled once every TICK_CYC cycles. A trial fails if trn_fail_i is 1 when done is seen, or if TIMEOUT_TICKS samples pass without done. A timed-out trial keeps trn_start_o high for exactly TIMEOUT_TICKS*TICK_CYC cycles. Failed trials drop trn_start_o.
- R9: On success, trn_start_o is dropped and bits [15:10] of dfe_word_i are captured as the trial figure. On the next cycle pat_rst_o is pulsed for one cycle with pat_en_o low. A failed trial produces no pat_rst_o pulse.
- R10: The best figure starts at 0. A successful trial replaces it only when that trial's figure is strictly greater, so ties keep the lower code.
- R11: If the best figure is 0 after the sweep, the run fails with no confirming trial, for exactly NUM_CODES training starts.
- R12: Otherwise, one more trial runs on the winning code. pass_o equals that trial's success, and best_code_o reports the winning code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| lane_sfi_i | input | 1 | Lane is configured for the SFI mode type |
| sq_det_i | input | 1 | Squelch detected (1 = no signal on the line) |
| cdr_lock_i | input | 1 | CDR locked |
| trn_done_i | input | 1 | PHY training complete |
| trn_fail_i | input | 1 | PHY training failed, valid with trn_done_i |
| dfe_word_i | input | 16 | Saved-equalizer status word, figure in [15:10] |
| sq_thresh_o | output | 4 | Squelch threshold |
| dgl_pos_o | output | 4 | Positive deglitch width |
| dgl_neg_o | output | 4 | Negative deglitch width |
| dgl_en_o | output | 1 | Deglitch enable |
| cdr_det_en_o | output | 1 | CDR lock detect enable |
| dfe_force_o | output | 1 | DFE result force |
| eq_cap_o | output | 4 | Equalizer capacitor select |
| eq_force_o | output | 1 | Equalizer setting force |
| eq_code_o | output | 3 | Equalizer resistor code under trial |
| pat_sel_o | output | 4 | Pattern checker select |
| pat_data_o | output | 8 | Pattern checker data value |
| pat_en_o | output | 1 | Pattern checker enable |
| pat_rst_o | output | 1 | Pattern checker counter reset |
| trn_start_o | output | 1 | Training start |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, one-cycle pulse |
| pass_o | output | 1 | Result of the last run |
| best_code_o | output | 3 | Chosen equalizer code |

## Verification
A stray state in the sequencer shows up at the ports within one trial. A skipped or repeated code makes the sequence of eq_code_o values seen at each rising trn_start_o depart from the ascending order. A bad pass/fail verdict shows as a missing or extra pat_rst_o pulse a cycle after the trial. A corrupted best tracker appears only at the end, as a wrong best_code_o or pass_o on done_o, or as a confirming trial on the wrong code. Timing faults in the delay and tick counters change the exact number of cycles the line-check abort takes and how long trn_start_o stays high on a timed-out code.

// File: rtl/eqsweep_pkg.sv
package eqsweep_pkg;

  localparam int WORD_W  = 16;
  localparam int RES_LSB = 10;
  localparam int RES_W   = 6;

  localparam logic [3:0] SQ_THRESH = 4'hC;
  localparam logic [3:0] DGL_WIDTH = 4'hF;
  localparam logic [3:0] EQ_CAP    = 4'hF;
  localparam logic [3:0] PAT_SEL   = 4'hE;
  localparam logic [7:0] PAT_DATA  = 8'h64;

  typedef enum logic [3:0] {
    S_IDLE,
    S_REJECT,
    S_SETTLE,
    S_CHECK,
    S_PREP,
    S_PAT,
    S_PWAIT,
    S_GO,
    S_POLL,
    S_CLR,
    S_REL,
    S_NEXT,
    S_DECIDE
  } seq_state_t;

  function automatic logic [RES_W-1:0] figure_of(input logic [WORD_W-1:0] w);
    return w[RES_LSB +: RES_W];
  endfunction

  function automatic logic beats(input logic [RES_W-1:0] cand,
                                 input logic [RES_W-1:0] best);
    return cand > best;
  endfunction

endpackage

// File: rtl/eqsweep_timer.sv
module eqsweep_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         fire_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load_i)          cnt <= len_i;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign fire_o = (cnt == W'(1));
endmodule

// File: rtl/eqsweep_best.sv
module eqsweep_best
  import eqsweep_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              upd_en_i,
  input  logic [RES_W-1:0]  cand_i,
  input  logic [CODE_W-1:0] cand_idx_i,
  output logic [RES_W-1:0]  best_val_o,
  output logic [CODE_W-1:0] best_idx_o,
  output logic              took_o
);
  assign took_o = upd_en_i && beats(cand_i, best_val_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_val_o <= '0;
      best_idx_o <= '0;
    end else if (clr_i) begin
      best_val_o <= '0;
      best_idx_o <= '0;
    end else if (took_o) begin
      best_val_o <= cand_i;
      best_idx_o <= cand_idx_i;
    end
  end
endmodule

// File: rtl/eqsweep_seq.sv
module eqsweep_seq
  import eqsweep_pkg::*;
#(
  parameter int SETTLE_CYC    = 12500,
  parameter int PAT_WAIT_CYC  = 6250000,
  parameter int TICK_CYC      = 125000,
  parameter int TIMEOUT_TICKS = 100,
  parameter int NUM_CODES     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         lane_sfi_i,
  input  logic                         sq_det_i,
  input  logic                         cdr_lock_i,
  input  logic                         trn_done_i,
  input  logic                         trn_fail_i,
  input  logic [15:0]                  dfe_word_i,
  output logic [3:0]                   sq_thresh_o,
  output logic [3:0]                   dgl_pos_o,
  output logic [3:0]                   dgl_neg_o,
  output logic                         dgl_en_o,
  output logic                         cdr_det_en_o,
  output logic                         dfe_force_o,
  output logic [3:0]                   eq_cap_o,
  output logic                         eq_force_o,
  output logic [$clog2(NUM_CODES)-1:0] eq_code_o,
  output logic [3:0]                   pat_sel_o,
  output logic [7:0]                   pat_data_o,
  output logic                         pat_en_o,
  output logic                         pat_rst_o,
  output logic                         trn_start_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         pass_o,
  output logic [$clog2(NUM_CODES)-1:0] best_code_o
);
  localparam int CODE_W  = $clog2(NUM_CODES);
  localparam int DLY_MAX = (SETTLE_CYC > PAT_WAIT_CYC) ? SETTLE_CYC : PAT_WAIT_CYC;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int TICK_W  = $clog2(TICK_CYC + 1);
  localparam int TO_W    = $clog2(TIMEOUT_TICKS + 1);

  seq_state_t        st;
  logic [CODE_W-1:0] trial_code;
  logic              confirm;
  logic              last_ok;
  logic [RES_W-1:0]  last_fig;
  logic [TO_W-1:0]   polls_left;

  // named internal events
  logic              dly_load, dly_fire;
  logic [DLY_W-1:0]  dly_len;
  logic              tick_load, tick_fire;
  logic              trial_ok, trial_bad;
  logic              best_clr, best_upd_en, best_upd;
  logic [RES_W-1:0]  best_val;
  logic [CODE_W-1:0] best_idx;

  assign busy_o    = (st != S_IDLE);
  assign dly_load  = (st == S_IDLE && start_i && lane_sfi_i) || (st == S_PAT);
  assign dly_len   = (st == S_IDLE) ? DLY_W'(SETTLE_CYC) : DLY_W'(PAT_WAIT_CYC);
  assign tick_load = (st == S_GO) || (st == S_POLL && tick_fire);

  assign trial_ok  = (st == S_POLL) && tick_fire && trn_done_i && !trn_fail_i;
  assign trial_bad = (st == S_POLL) && tick_fire &&
                     ((trn_done_i && trn_fail_i) ||
                      (!trn_done_i && polls_left == TO_W'(1)));

  assign best_clr    = (st == S_IDLE) && start_i;
  assign best_upd_en = (st == S_NEXT) && last_ok && !confirm;

  eqsweep_timer #(.W(DLY_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (dly_load),
    .len_i  (dly_len),
    .fire_o (dly_fire)
  );

  eqsweep_timer #(.W(TICK_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tick_load),
    .len_i  (TICK_W'(TICK_CYC)),
    .fire_o (tick_fire)
  );

  eqsweep_best #(.CODE_W(CODE_W)) u_best (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (best_clr),
    .upd_en_i   (best_upd_en),
    .cand_i     (last_fig),
    .cand_idx_i (trial_code),
    .best_val_o (best_val),
    .best_idx_o (best_idx),
    .took_o     (best_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      trial_code   <= '0;
      confirm      <= 1'b0;
      last_ok      <= 1'b0;
      last_fig     <= '0;
      polls_left   <= '0;
      sq_thresh_o  <= '0;
      dgl_pos_o    <= '0;
      dgl_neg_o    <= '0;
      dgl_en_o     <= 1'b0;
      cdr_det_en_o <= 1'b0;
      dfe_force_o  <= 1'b1;
      eq_cap_o     <= '0;
      eq_force_o   <= 1'b0;
      eq_code_o    <= '0;
      pat_sel_o    <= '0;
      pat_data_o   <= '0;
      pat_en_o     <= 1'b0;
      pat_rst_o    <= 1'b0;
      trn_start_o  <= 1'b0;
      done_o       <= 1'b0;
      pass_o       <= 1'b0;
      best_code_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            pass_o <= 1'b0;
            if (!lane_sfi_i) begin
              st <= S_REJECT;
            end else begin
              sq_thresh_o  <= SQ_THRESH;
              dgl_pos_o    <= DGL_WIDTH;
              dgl_neg_o    <= DGL_WIDTH;
              dgl_en_o     <= 1'b1;
              cdr_det_en_o <= 1'b1;
              st           <= S_SETTLE;
            end
          end
        end
        S_REJECT: begin
          done_o      <= 1'b1;
          pass_o      <= 1'b0;
          best_code_o <= best_idx;
          st          <= S_IDLE;
        end
        S_SETTLE: if (dly_fire) st <= S_CHECK;
        S_CHECK: begin
          if (sq_det_i || !cdr_lock_i) begin
            done_o      <= 1'b1;
            pass_o      <= 1'b0;
            best_code_o <= best_idx;
            st          <= S_IDLE;
          end else begin
            st <= S_PREP;
          end
        end
        S_PREP: begin
          dfe_force_o <= 1'b0;
          eq_cap_o    <= EQ_CAP;
          eq_force_o  <= 1'b1;
          trial_code  <= '0;
          confirm     <= 1'b0;
          st          <= S_PAT;
        end
        S_PAT: begin
          pat_sel_o  <= PAT_SEL;
          pat_data_o <= PAT_DATA;
          pat_en_o   <= 1'b1;
          st         <= S_PWAIT;
        end
        S_PWAIT: if (dly_fire) st <= S_GO;
        S_GO: begin
          eq_code_o   <= trial_code;
          trn_start_o <= 1'b1;
          polls_left  <= TO_W'(TIMEOUT_TICKS);
          st          <= S_POLL;
        end
        S_POLL: begin
          if (trial_ok) begin
            trn_start_o <= 1'b0;
            last_ok     <= 1'b1;
            last_fig    <= figure_of(dfe_word_i);
            st          <= S_CLR;
          end else if (trial_bad) begin
            trn_start_o <= 1'b0;
            last_ok     <= 1'b0;
            st          <= S_NEXT;
          end else if (tick_fire) begin
            polls_left  <= polls_left - 1'b1;
          end
        end
        S_CLR: begin
          pat_rst_o <= 1'b1;
          pat_en_o  <= 1'b0;
          st        <= S_REL;
        end
        S_REL: begin
          pat_rst_o <= 1'b0;
          st        <= S_NEXT;
        end
        S_NEXT: begin
          if (confirm) begin
            done_o      <= 1'b1;
            pass_o      <= last_ok;
            best_code_o <= best_idx;
            st          <= S_IDLE;
          end else if (trial_code == CODE_W'(NUM_CODES - 1)) begin
            st <= S_DECIDE;
          end else begin
            trial_code <= trial_code + 1'b1;
            st         <= S_PAT;
          end
        end
        S_DECIDE: begin
          if (best_val == '0) begin
            done_o      <= 1'b1;
            pass_o      <= 1'b0;
            best_code_o <= best_idx;
            st          <= S_IDLE;
          end else begin
            trial_code <= best_idx;
            confirm    <= 1'b1;
            st         <= S_PAT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eqsweep_chk.sv
module eqsweep_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              lane_sfi_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              trn_start_o,
  input logic              pat_en_o,
  input logic              pat_rst_o,
  input logic              eq_force_o,
  input logic [CODE_W-1:0] eq_code_o,
  input logic              trial_ok,
  input logic              trial_bad
);
  // R2
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_train_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trn_start_o |-> busy_o);
  // R3
  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !lane_sfi_i) |=> busy_o ##1 (done_o && !pass_o));
  // R7
  p_start_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trn_start_o |-> (pat_en_o && eq_force_o));
  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_start_o && $past(trn_start_o)) |-> $stable(eq_code_o));
  // R8
  p_verdict_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(trial_ok && trial_bad));
  p_fail_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trial_bad |=> (!trn_start_o && !pat_rst_o));
  // R9
  p_ok_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trial_ok |=> !trn_start_o ##1 pat_rst_o);
  p_ckr_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rst_o |-> (!pat_en_o && !trn_start_o));
  p_ckr_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rst_o |=> !pat_rst_o);
endmodule

bind eqsweep_seq eqsweep_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .lane_sfi_i  (lane_sfi_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .trn_start_o (trn_start_o),
  .pat_en_o    (pat_en_o),
  .pat_rst_o   (pat_rst_o),
  .eq_force_o  (eq_force_o),
  .eq_code_o   (eq_code_o),
  .trial_ok    (trial_ok),
  .trial_bad   (trial_bad)
);

// File: tb/eqsweep_seq_test.sv
module eqsweep_seq_test;
  localparam int SETTLE = 20;
  localparam int PATW   = 30;
  localparam int TICK   = 8;
  localparam int TOUT   = 6;
  localparam int NC     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, lane_sfi_i = 1'b1, sq_det_i = 1'b0, cdr_lock_i = 1'b1;
  logic trn_done_i = 1'b0, trn_fail_i = 1'b0;
  logic [15:0] dfe_word_i = '0;
  logic [3:0] sq_thresh_o, dgl_pos_o, dgl_neg_o, eq_cap_o, pat_sel_o;
  logic [7:0] pat_data_o;
  logic dgl_en_o, cdr_det_en_o, dfe_force_o, eq_force_o, pat_en_o, pat_rst_o;
  logic trn_start_o, busy_o, done_o, pass_o;
  logic [2:0] eq_code_o, best_code_o;

  always #4 clk = ~clk;

  eqsweep_seq #(.SETTLE_CYC(SETTLE), .PAT_WAIT_CYC(PATW), .TICK_CYC(TICK),
                .TIMEOUT_TICKS(TOUT), .NUM_CODES(NC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lane_sfi_i(lane_sfi_i),
    .sq_det_i(sq_det_i), .cdr_lock_i(cdr_lock_i), .trn_done_i(trn_done_i),
    .trn_fail_i(trn_fail_i), .dfe_word_i(dfe_word_i),
    .sq_thresh_o(sq_thresh_o), .dgl_pos_o(dgl_pos_o), .dgl_neg_o(dgl_neg_o),
    .dgl_en_o(dgl_en_o), .cdr_det_en_o(cdr_det_en_o), .dfe_force_o(dfe_force_o),
    .eq_cap_o(eq_cap_o), .eq_force_o(eq_force_o), .eq_code_o(eq_code_o),
    .pat_sel_o(pat_sel_o), .pat_data_o(pat_data_o), .pat_en_o(pat_en_o),
    .pat_rst_o(pat_rst_o), .trn_start_o(trn_start_o), .busy_o(busy_o),
    .done_o(done_o), .pass_o(pass_o), .best_code_o(best_code_o));

  int vectors = 0, fails = 0, cycles = 0;
  int res_tab[NC];
  bit fail_tab[NC], hang_tab[NC], fail2_tab[NC];
  int att[NC];
  int code_q[$];
  int pass_q[$];
  int bestc_q[$];
  int n_starts = 0, n_rst = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural PHY
  bit ph_prev = 1'b0;
  int ph_cnt = 0, ph_code = 0;
  always @(negedge clk) begin
    if (!trn_start_o) begin
      trn_done_i <= 1'b0;
      trn_fail_i <= 1'b0;
    end else if (!ph_prev) begin
      ph_code = int'(eq_code_o);
      att[ph_code]++;
      ph_cnt = 0;
    end else begin
      ph_cnt++;
      if (ph_cnt == 5 + 4 * ph_code && !hang_tab[ph_code]) begin
        trn_done_i <= 1'b1;
        trn_fail_i <= fail_tab[ph_code] || (att[ph_code] >= 2 && fail2_tab[ph_code]);
        dfe_word_i <= 16'((res_tab[ph_code] & 63) << 10) | 16'h015A;
      end
    end
    ph_prev = trn_start_o;
  end

  // monitor
  bit mon_ts = 1'b0, mon_rst = 1'b0;
  int hi_len = 0, mon_code = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (trn_start_o && !mon_ts) begin
        n_starts++;
        hi_len = 0;
        mon_code = int'(eq_code_o);
        if (code_q.size() == 0)
          chk(1'b0, "R7", "unexpected trial code", int'(eq_code_o), -1);
        else begin
          int e;
          e = code_q.pop_front();
          chk(int'(eq_code_o) == e, "R7 R12", "trial code order", int'(eq_code_o), e);
        end
        chk(pat_sel_o == 4'hE && pat_data_o == 8'h64 && pat_en_o, "R7",
            "pattern setup at training start", {pat_sel_o, pat_data_o}, 'hE64);
        chk(eq_cap_o == 4'hF && eq_force_o && !dfe_force_o, "R6",
            "equalizer prep", {eq_cap_o, eq_force_o, dfe_force_o}, 'h3E);
        chk(sq_thresh_o == 4'hC && dgl_pos_o == 4'hF && dgl_neg_o == 4'hF &&
            dgl_en_o && cdr_det_en_o, "R4", "line config",
            {sq_thresh_o, dgl_pos_o, dgl_neg_o}, 'hCFF);
      end
      if (trn_start_o) hi_len++;
      if (!trn_start_o && mon_ts && hang_tab[mon_code])
        chk(hi_len == TOUT * TICK, "R8", "timeout trial length", hi_len, TOUT * TICK);
      if (pat_rst_o && !mon_rst) n_rst++;
      if (done_o) begin
        if (pass_q.size() == 0)
          chk(1'b0, "R2", "unexpected done", 1, 0);
        else begin
          int ep, eb;
          ep = pass_q.pop_front();
          eb = bestc_q.pop_front();
          chk(int'(pass_o) == ep, "R12 R10", "pass flag", int'(pass_o), ep);
          chk(int'(best_code_o) == eb, "R10 R12", "chosen code", int'(best_code_o), eb);
        end
      end
    end
    mon_ts  = trn_start_o;
    mon_rst = pat_rst_o;
  end

  // driver: computes expectations from the requirements, runs one case
  task automatic run_case(input string tag, input bit sfi, input bit sq,
                          input bit cdr, input bit poke, output int k);
    int best, idx, n_ok, n_tr, st0, rs0;
    bit ok;
    best = 0; idx = 0; n_ok = 0; n_tr = 0;
    if (sfi && !sq && cdr) begin
      for (int i = 0; i < NC; i++) begin
        code_q.push_back(i);
        n_tr++;
        ok = !hang_tab[i] && !fail_tab[i];
        if (ok) n_ok++;
        if (ok && res_tab[i] > best) begin best = res_tab[i]; idx = i; end
      end
      if (best == 0) pass_q.push_back(0);
      else begin
        code_q.push_back(idx);
        n_tr++;
        ok = !hang_tab[idx] && !fail_tab[idx] && !fail2_tab[idx];
        if (ok) n_ok++;
        pass_q.push_back(ok ? 1 : 0);
      end
    end else pass_q.push_back(0);
    bestc_q.push_back(idx);
    for (int i = 0; i < NC; i++) att[i] = 0;
    st0 = n_starts; rs0 = n_rst;
    lane_sfi_i = sfi; sq_det_i = sq; cdr_lock_i = cdr;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    k = 1;
    if (poke) begin
      repeat (199) @(negedge clk);
      k += 199;
      chk(busy_o == 1'b1, "R2", {tag, " busy mid-run"}, int'(busy_o), 1);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      k++;
    end
    while (!done_o && k < 6000) begin
      @(negedge clk);
      k++;
    end
    chk(done_o == 1'b1 && busy_o == 1'b0, "R2", {tag, " done with busy low"},
        {done_o, busy_o}, 2);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R2", {tag, " done one cycle"},
        {done_o, busy_o}, 0);
    repeat (3) @(negedge clk);
    chk(code_q.size() == 0, "R7", {tag, " trials missing"}, code_q.size(), 0);
    chk(n_starts - st0 == n_tr, "R11", {tag, " training starts"}, n_starts - st0, n_tr);
    chk(n_rst - rs0 == n_ok, "R9", {tag, " checker reset pulses"}, n_rst - rs0, n_ok);
  endtask

  task automatic set_tab(input int r0, input int r1, input int r2, input int r3,
                         input int r4, input int r5, input int r6, input int r7);
    res_tab = '{r0, r1, r2, r3, r4, r5, r6, r7};
    for (int i = 0; i < NC; i++) begin
      fail_tab[i] = 0; hang_tab[i] = 0; fail2_tab[i] = 0;
    end
  endtask

  initial begin
    int k;
    set_tab(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !pass_o && !trn_start_o && !pat_en_o && !pat_rst_o,
        "R1", "reset outputs", {busy_o, done_o, pass_o, trn_start_o, pat_en_o, pat_rst_o}, 0);
    chk(best_code_o == 0 && dfe_force_o == 1'b1, "R1", "reset code/force",
        {best_code_o, dfe_force_o}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 wrong lane type
    run_case("nonsfi", 1'b0, 1'b0, 1'b1, 1'b0, k);
    chk(k == 2, "R3", "reject latency", k, 2);

    // R5 no signal, then no lock
    run_case("squelch", 1'b1, 1'b1, 1'b1, 1'b0, k);
    chk(k == SETTLE + 2, "R5 R4", "squelch abort latency", k, SETTLE + 2);
    run_case("nolock", 1'b1, 1'b0, 1'b0, 1'b0, k);
    chk(k == SETTLE + 2, "R5", "lock abort latency", k, SETTLE + 2);

    // distinct figures, with a start poke mid-run (R2)
    set_tab(5, 9, 3, 17, 2, 11, 8, 1);
    run_case("distinct", 1'b1, 1'b0, 1'b1, 1'b1, k);

    // ties keep the lower code (R10)
    set_tab(4, 12, 12, 7, 12, 0, 3, 12);
    run_case("ties", 1'b1, 1'b0, 1'b1, 1'b0, k);

    // failed and timed-out codes with top figures are ignored (R8)
    set_tab(6, 10, 40, 9, 3, 50, 10, 2);
    fail_tab[2] = 1; hang_tab[5] = 1;
    run_case("faulty", 1'b1, 1'b0, 1'b1, 1'b0, k);

    // all figures zero (R11)
    set_tab(0, 0, 0, 0, 0, 0, 0, 0);
    run_case("zeros", 1'b1, 1'b0, 1'b1, 1'b0, k);

    // every trial fails (R11)
    set_tab(5, 9, 3, 17, 2, 11, 8, 1);
    for (int i = 0; i < NC; i++) fail_tab[i] = 1;
    run_case("allfail", 1'b1, 1'b0, 1'b1, 1'b0, k);

    // confirming trial fails (R12)
    set_tab(5, 9, 3, 17, 2, 11, 8, 1);
    fail2_tab[3] = 1;
    run_case("confirm_fail", 1'b1, 1'b0, 1'b1, 1'b0, k);

    // winner on the last code, timeout elsewhere (R10 R8)
    set_tab(1, 2, 3, 4, 5, 6, 7, 63);
    hang_tab[0] = 1;
    run_case("last", 1'b1, 1'b0, 1'b1, 1'b0, k);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule